// File: doc/BRIEF.md
# Linear Systolic SAD Search Array

This block runs a full-search motion estimate for one 16x16 macroblock over a window of −8 to +7 pixels in both directions. Sixteen processing elements sit in a linear chain. Element i always evaluates the horizontal offset dx = i − 8. A controller steps the vertical offset, and within each vertical offset it steps the sixteen 4x4 sub-blocks and their four pixel rows. Each cycle, one row of four current-frame pixels enters the chain, together with a strip of nineteen reference pixels. A register stage in every element delays both by one cycle toward the next element. Each element picks the four strip pixels that match its own offset, so element i starts i cycles after element 0 on the same data.

Each element accumulates absolute differences over the four rows of a sub-block. It then publishes a 4x4 SAD in its own result register, tagged with the sub-block index and the motion vector. The chain fills in 16 cycles, and from then on every element produces one result every 4 cycles. Frame memory lies outside the block. A streaming source answers the controller's row, sub-block and offset indices with pixel data in the cycle those indices are shown. Combining the 4x4 results into larger block sizes is left to a downstream stage.

Top module: `sad_search_array`

## Requirements
- R1: After reset, feed_req, done and every res_valid bit are 0, and they stay 0 until start is sampled high.
- R2: A start sampled at a rising edge while idle makes feed_req high in the following cycle. The index outputs step in this order: feed_row (0..3, pixel row y = 4·(blk/4) + row) changes fastest, then feed_blk (0..15, blk = 4·block_row + block_col), then feed_dyi (0..15, vertical offset dy = feed_dyi − 8).
- R3: feed_req stays high for exactly 1024 consecutive cycles per search. The data present on cur_row and ref_strip in each of those cycles is consumed at the closing edge.
- R4: cur_row pixel k (bits 8k+7:8k) is column 4·block_col + k of the current row. ref_strip pixel j (bits 8j+7:8j) is column 4·block_col − 8 + j of reference row y + dy. Element i reports the sum over the 4x4 sub-block of |cur − ref|, using strip pixels i..i+3.
- R5: The result of element i for a sub-block appears exactly i cycles after the result of element 0 for that sub-block. Element 0's result appears two cycles after the cycle that carried the sub-block's fourth row.
- R6: Once the chain is full, each element raises res_valid for one cycle in every four, and it does so for all 256 sub-block/offset groups of a search.
- R7: Every result carries res_mvx = i − 8 and res_mvy = feed_dyi − 8 as 5-bit two's complement, plus res_blk equal to the sub-block index of R2.
- R8: done is a one-cycle pulse. It is high in the same cycle as element 15's final result, 1040 rising edges after the edge that sampled start.
- R9: start sampled while a search is running, including during the 16-cycle drain, has no effect on the sequence of feed indices, results or done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a search when sampled high while idle |
| cur_row | input | 32 | Four current-frame pixels of the requested row |
| ref_strip | input | 152 | Nineteen reference pixels covering all horizontal offsets |
| feed_req | output | 1 | Pixel data is consumed at the end of this cycle |
| feed_row | output | 2 | Requested row within the sub-block |
| feed_blk | output | 4 | Requested sub-block index |
| feed_dyi | output | 4 | Requested vertical offset index (dy + 8) |
| done | output | 1 | One-cycle end-of-search pulse |
| res_valid | output | 16 | Per-element result strobe |
| res_sad | output | 192 | Per-element 12-bit 4x4 SAD |
| res_blk | output | 64 | Per-element 4-bit sub-block tag |
| res_mvx | output | 80 | Per-element 5-bit horizontal vector |
| res_mvy | output | 80 | Per-element 5-bit vertical vector |

## Verification
The end-of-search pulse shares a cycle with the last result of element 15. The bench therefore checks, in that single cycle, that done, res_valid[15] and its SAD and vector are all correct. Stray start pulses are sent in the middle of the feed phase and inside the drain window, where the controller is still busy and no data is being requested. Each is judged by the full per-cycle expectation of feed indices, result strobes and the done cycle, all computed from the start edge alone. Random frames carrying a planted shifted copy give zero SADs at one position. A saturated frame pair gives the maximum SAD of 4080.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int ROWW = 2;
  localparam int BLKW = 4;
  localparam int DYW  = 4;

  typedef struct packed {
    logic            vld;
    logic [ROWW-1:0] row;
    logic [BLKW-1:0] blk;
    logic [DYW-1:0]  dyi;
  } tag_t;
endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
#(
  parameter int NPE  = 16,
  parameter int NBLK = 16,
  parameter int BW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            feed_req,
  output logic [ROWW-1:0] feed_row,
  output logic [BLKW-1:0] feed_blk,
  output logic [DYW-1:0]  feed_dyi,
  output logic            done
);
  localparam int FEED = NPE * NBLK * BW;
  localparam int LAST = FEED + NPE - 1;
  localparam int CW   = $clog2(FEED + NPE + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          run <= 1'b1;
          cnt <= '0;
        end
      end else if (cnt == CW'(LAST)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign feed_req = run && (cnt < CW'(FEED));
  assign feed_row = cnt[ROWW-1:0];
  assign feed_blk = cnt[ROWW +: BLKW];
  assign feed_dyi = cnt[ROWW+BLKW +: DYW];
endmodule

// File: rtl/sad_pe.sv
module sad_pe
  import sad_pkg::*;
#(
  parameter int PIXW   = 8,
  parameter int BW     = 4,
  parameter int STRIPN = 19,
  parameter int IDX    = 0,
  parameter int SADW   = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  tag_t                   in_tag,
  input  logic [BW*PIXW-1:0]     in_cur,
  input  logic [STRIPN*PIXW-1:0] in_strip,
  output tag_t                   out_tag,
  output logic [BW*PIXW-1:0]     out_cur,
  output logic [STRIPN*PIXW-1:0] out_strip,
  output logic                   res_vld,
  output logic [SADW-1:0]        res_sad,
  output logic [BLKW-1:0]        res_blk,
  output logic [DYW-1:0]         res_dyi
);
  localparam int ROWSW = PIXW + $clog2(BW) + 1;

  tag_t                   tag_q;
  logic [BW*PIXW-1:0]     cur_q;
  logic [STRIPN*PIXW-1:0] strip_q;
  logic [SADW-1:0]        acc;
  logic [ROWSW-1:0]       rowsum;

  function automatic logic [PIXW-1:0] absd(input logic [PIXW-1:0] a, input logic [PIXW-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  // delay stage shared with the next element
  always_ff @(posedge clk) begin
    if (rst) tag_q <= '0;
    else     tag_q <= in_tag;
    cur_q   <= in_cur;
    strip_q <= in_strip;
  end

  always_comb begin
    rowsum = '0;
    for (int k = 0; k < BW; k++)
      rowsum = rowsum + ROWSW'(absd(cur_q[k*PIXW +: PIXW], strip_q[(IDX+k)*PIXW +: PIXW]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      res_vld <= 1'b0;
      res_sad <= '0;
      res_blk <= '0;
      res_dyi <= '0;
    end else begin
      res_vld <= tag_q.vld && (tag_q.row == ROWW'(BW-1));
      if (tag_q.vld) begin
        acc <= ((tag_q.row == '0) ? '0 : acc) + SADW'(rowsum);
        if (tag_q.row == ROWW'(BW-1)) begin
          res_sad <= acc + SADW'(rowsum);
          res_blk <= tag_q.blk;
          res_dyi <= tag_q.dyi;
        end
      end
    end
  end

  assign out_tag   = tag_q;
  assign out_cur   = cur_q;
  assign out_strip = strip_q;
endmodule

// File: rtl/sad_search_array.sv
module sad_search_array
  import sad_pkg::*;
#(
  parameter int NPE  = 16,
  parameter int PIXW = 8,
  parameter int BW   = 4,
  parameter int NBLK = 16,
  parameter int MVW  = 5,
  parameter int SADW = 2*PIXW - 4,
  parameter int STRIPN = NPE + BW - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [BW*PIXW-1:0]     cur_row,
  input  logic [STRIPN*PIXW-1:0] ref_strip,
  output logic                   feed_req,
  output logic [ROWW-1:0]        feed_row,
  output logic [BLKW-1:0]        feed_blk,
  output logic [DYW-1:0]         feed_dyi,
  output logic                   done,
  output logic [NPE-1:0]         res_valid,
  output logic [NPE*SADW-1:0]    res_sad,
  output logic [NPE*BLKW-1:0]    res_blk,
  output logic [NPE*MVW-1:0]     res_mvx,
  output logic [NPE*MVW-1:0]     res_mvy
);
  tag_t                   tag_c   [NPE+1];
  logic [BW*PIXW-1:0]     cur_c   [NPE+1];
  logic [STRIPN*PIXW-1:0] strip_c [NPE+1];
  logic [DYW-1:0]         dyi_r   [NPE];

  sad_ctrl #(.NPE(NPE), .NBLK(NBLK), .BW(BW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .feed_req(feed_req), .feed_row(feed_row), .feed_blk(feed_blk),
    .feed_dyi(feed_dyi), .done(done)
  );

  assign tag_c[0]   = '{vld: feed_req, row: feed_row, blk: feed_blk, dyi: feed_dyi};
  assign cur_c[0]   = cur_row;
  assign strip_c[0] = ref_strip;

  for (genvar i = 0; i < NPE; i++) begin : g_pe
    sad_pe #(.PIXW(PIXW), .BW(BW), .STRIPN(STRIPN), .IDX(i), .SADW(SADW)) u_pe (
      .clk(clk), .rst(rst),
      .in_tag(tag_c[i]), .in_cur(cur_c[i]), .in_strip(strip_c[i]),
      .out_tag(tag_c[i+1]), .out_cur(cur_c[i+1]), .out_strip(strip_c[i+1]),
      .res_vld(res_valid[i]),
      .res_sad(res_sad[i*SADW +: SADW]),
      .res_blk(res_blk[i*BLKW +: BLKW]),
      .res_dyi(dyi_r[i])
    );
    assign res_mvx[i*MVW +: MVW] = MVW'(i) - MVW'(NPE/2);
    assign res_mvy[i*MVW +: MVW] = MVW'(dyi_r[i]) - MVW'(NPE/2);
  end
endmodule

// File: rtl/sad_search_array_chk.sv
module sad_search_array_chk #(
  parameter int NPE = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           feed_req,
  input logic           done,
  input logic [NPE-1:0] res_valid
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (rst) done |-> res_valid[NPE-1]); // R8
  AST_FEED_FROM_START: assert property (@(posedge clk) disable iff (rst) $rose(feed_req) |-> $past(start)); // R2
  AST_DONE_NO_FEED: assert property (@(posedge clk) disable iff (rst) done |-> !feed_req); // R3
  AST_PE0_GAP: assert property (@(posedge clk) disable iff (rst) res_valid[0] |=> !res_valid[0]); // R6
  for (genvar g = 0; g < NPE-1; g++) begin : g_skew
    AST_SKEW_STEP: assert property (@(posedge clk) disable iff (rst) res_valid[g] |=> res_valid[g+1]); // R5
  end
endmodule

bind sad_search_array sad_search_array_chk #(.NPE(NPE)) u_chk (
  .clk(clk), .rst(rst), .start(start), .feed_req(feed_req),
  .done(done), .res_valid(res_valid)
);

// File: tb/sad_search_array_bench.sv
module sad_search_array_bench;
  localparam int NPE = 16;
  localparam int STRIPN = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] cur_row = '0;
  logic [STRIPN*8-1:0] ref_strip = '0;
  logic feed_req, done;
  logic [1:0] feed_row;
  logic [3:0] feed_blk, feed_dyi;
  logic [NPE-1:0] res_valid;
  logic [NPE*12-1:0] res_sad;
  logic [NPE*4-1:0] res_blk;
  logic [NPE*5-1:0] res_mvx, res_mvy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] cur_m [16][16];
  logic [7:0] ref_m [31][31];

  always #10 clk = ~clk;

  sad_search_array u_sad_search_array (
    .clk(clk), .rst(rst), .start(start), .cur_row(cur_row), .ref_strip(ref_strip),
    .feed_req(feed_req), .feed_row(feed_row), .feed_blk(feed_blk), .feed_dyi(feed_dyi),
    .done(done), .res_valid(res_valid), .res_sad(res_sad), .res_blk(res_blk),
    .res_mvx(res_mvx), .res_mvy(res_mvy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sad_exp(input int i, input int blk, input int dyi);
    int s = 0;
    int by = blk / 4, bx = blk % 4;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        int a = cur_m[by*4+r][bx*4+c];
        int b = ref_m[by*4+r+dyi][bx*4+c+i];
        s += (a > b) ? a - b : b - a;
      end
    return s;
  endfunction

  function automatic bit vld_exp(input int i, input int k);
    int m = k - i - 2;
    return (m >= 3) && (m <= 1023) && (m % 4 == 3);
  endfunction

  task automatic drive(input int k);
    int row = k % 4, blk = (k / 4) % 16, dyi = k / 64;
    int y = (blk / 4) * 4 + row, bx = blk % 4;
    if (k < 0 || k > 1023) return;
    for (int c = 0; c < 4; c++) cur_row[c*8 +: 8] = cur_m[y][bx*4+c];
    for (int j = 0; j < STRIPN; j++) ref_strip[j*8 +: 8] = ref_m[y+dyi][bx*4+j];
  endtask

  task automatic run_search(input int stray1, input int stray2);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= 1046; k++) begin
      @(negedge clk);
      start = (k == stray1 || k == stray2);
      chk(feed_req == (k <= 1023), "R3 feed_req window", feed_req, k <= 1023);
      if (k <= 1023) begin
        chk({feed_dyi, feed_blk, feed_row} == 10'(k), "R2 feed index order",
            {feed_dyi, feed_blk, feed_row}, k);
      end
      chk(done == (k == 1040), "R8 done cycle", done, k == 1040);
      for (int i = 0; i < NPE; i++) begin
        bit ev = vld_exp(i, k);
        chk(res_valid[i] == ev, "R5/R6 res_valid timing", res_valid[i], ev);
        if (ev && res_valid[i]) begin
          int g = (k - i - 2) / 4;
          int blk = g % 16, dyi = g / 16;
          int es = sad_exp(i, blk, dyi);
          chk(res_sad[i*12 +: 12] == 12'(es), "R4 sad value", res_sad[i*12 +: 12], es);
          chk(res_blk[i*4 +: 4] == 4'(blk), "R7 blk tag", res_blk[i*4 +: 4], blk);
          chk($signed(res_mvx[i*5 +: 5]) == i - 8, "R7 mvx", $signed(res_mvx[i*5 +: 5]), i - 8);
          chk($signed(res_mvy[i*5 +: 5]) == dyi - 8, "R7 mvy", $signed(res_mvy[i*5 +: 5]), dyi - 8);
        end
      end
      drive(k);
    end
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int y = 0; y < 16; y++) for (int x = 0; x < 16; x++) cur_m[y][x] = 8'($urandom);
    for (int y = 0; y < 31; y++) for (int x = 0; x < 31; x++) ref_m[y][x] = 8'($urandom);
    // planted copy at dx = -5, dy = +3: zero SAD expected there
    for (int y = 0; y < 16; y++) for (int x = 0; x < 16; x++) ref_m[y+3+8][x-5+8] = cur_m[y][x];
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(!feed_req && !done && res_valid == '0, "R1 reset state", {feed_req, done, |res_valid}, 0);
    end
    // R9: stray start mid-feed and during drain
    run_search(500, 1030);
    repeat (3) begin
      @(negedge clk);
      chk(!feed_req && res_valid == '0, "R9 no rerun after strays", feed_req, 0);
    end
    chk(sad_exp(3, 5, 11) == 0, "R4 planted copy model", sad_exp(3, 5, 11), 0);
    // saturated corner: every SAD is 4080
    for (int y = 0; y < 16; y++) for (int x = 0; x < 16; x++) cur_m[y][x] = 8'hFF;
    for (int y = 0; y < 31; y++) for (int x = 0; x < 31; x++) ref_m[y][x] = 8'h00;
    run_search(-10, -10);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule